// File: doc/BRIEF.md
# Windowed Coincidence Detector Neuron

This block is one spiking neuron for an address-event network that stores timing patterns. It watches a shared pre-synaptic event bus. The bus has no handshake. It carries a linear binary address and four active lines, one per synapse. When the bus address equals the neuron's own address, each asserted active line hits the matching synapse. That hit starts a per-synapse timer, which counts the cycles elapsed since the hit.

The neuron declares a coincidence when three synapses are live at once. Hits that arrive on the same cycle count together. On a coincidence, all timers clear. The neuron then waits for a delay equal to the sum of the timer ages at that moment, so widely spread inputs give a later output. After the delay it emits a one-cycle strobe with its own address on the post-synaptic bus, and then stays deaf for a refractory period. The window length, the refractory length and the clock rate are parameters, given in microseconds and kHz.

Top module: `coinc_neuron`

## Requirements
- R1: After reset, postActive is low, and no spike is produced while no input arrives.
- R2: A hit is taken only when preAddr equals selfAddr. Events carrying any other address change nothing.
- R3: Let W be the window length in cycles. A hit sampled at edge E stays live for coincidence through edge E+W-1. It has expired at edge E+W.
- R4: A hit on a synapse whose timer is still live is ignored. It does not restart the timer and does not change the delay.
- R5: A coincidence needs at least three synapses live at the same edge, counting hits sampled at that edge. Two live synapses never fire.
- R6: Let the coincidence be sampled at edge E, with S the sum of the ages (in cycles) of the synapses already live, a same-edge hit counting as age 0. postActive then rises at edge E+S+1.
- R7: postActive is high for exactly one cycle, and postAddr equals selfAddr while it is high.
- R8: Let R be the refractory length in cycles. Input sampled at the R edges after the firing edge is ignored. Input sampled at the next edge is accepted again.
- R9: While a delayed spike is pending, input is ignored, so one burst yields exactly one spike.
- R10: All synapse timers clear when a coincidence is taken. Hits that came before it cannot combine with hits that come after the refractory period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| selfAddr | input | ADDR_W | Address of this neuron |
| preAddr | input | ADDR_W | Pre-synaptic bus address |
| preActive | input | NUM_SYN | Pre-synaptic active lines, bit i hits synapse i |
| postAddr | output | ADDR_W | Post-synaptic bus address, always selfAddr |
| postActive | output | 1 | One-cycle output spike strobe |

## Verification
The bench drives each event at a falling edge, so it is sampled at the next rising edge, and it records the index of that edge. The output strobe is registered, so for a coincidence sampled at edge E with an age sum S, the strobe is first visible after edge E+S+1. The bench samples postActive at falling edges, tagging each sighting with the preceding rising-edge index, and compares that index with the value computed from the recorded hit edges.

Window and refractory boundaries are probed on the exact edges W-1 and W after a hit, and R and R+1 after a firing. Each probe waits longer than the largest delay the stimulus could produce before it concludes that no spike followed.

// File: rtl/coinc_neuron_pkg.sv
package coinc_neuron_pkg;

  // Strobes from the fire control to the synapse datapath
  typedef struct packed {
    logic accept;    // hits may be taken this cycle
    logic clearAll;  // hold every synapse timer cleared
  } nrnStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_REFR = 2'd2
  } nrnState_t;

endpackage

// File: rtl/coinc_synapse_dp.sv
module coinc_synapse_dp
  import coinc_neuron_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_SYN    = 4,
  parameter int THRESH     = 3,
  parameter int WINDOW_CYC = 64,
  parameter int TMR_W      = 7,
  parameter int SUM_W      = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  selfAddr,
  input  logic [ADDR_W-1:0]  preAddr,
  input  logic [NUM_SYN-1:0] preActive,
  input  nrnStrobe_t         strb,
  output logic               coinc,
  output logic [SUM_W-1:0]   delaySum,
  output logic [NUM_SYN-1:0] tmrLive
);

  localparam int PC_W = $clog2(NUM_SYN + 1);

  logic [TMR_W-1:0]   tmrVal [NUM_SYN];
  logic [NUM_SYN-1:0] hitVec;
  logic               addrHit;
  logic [PC_W-1:0]    liveCount;

  always_comb begin
    addrHit = (preAddr == selfAddr);
    for (int i = 0; i < NUM_SYN; i++) begin
      hitVec[i] = strb.accept && addrHit && preActive[i] && !tmrLive[i];
    end
  end

  // Count synapses live now plus new hits; sum ages of the live ones
  always_comb begin
    liveCount = '0;
    delaySum  = '0;
    for (int i = 0; i < NUM_SYN; i++) begin
      liveCount = liveCount + PC_W'(tmrLive[i] | hitVec[i]);
      if (tmrLive[i]) delaySum = delaySum + SUM_W'(tmrVal[i]);
    end
    coinc = (liveCount >= PC_W'(THRESH));
  end

  // One age timer per synapse
  for (genvar g = 0; g < NUM_SYN; g++) begin : gSyn
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tmrLive[g] <= 1'b0;
        tmrVal[g]  <= '0;
      end else if (strb.clearAll || coinc) begin
        tmrLive[g] <= 1'b0;
        tmrVal[g]  <= '0;
      end else if (hitVec[g]) begin
        tmrLive[g] <= 1'b1;
        tmrVal[g]  <= TMR_W'(1);
      end else if (tmrLive[g]) begin
        if (tmrVal[g] == TMR_W'(WINDOW_CYC - 1)) begin
          tmrLive[g] <= 1'b0;
          tmrVal[g]  <= '0;
        end else begin
          tmrVal[g] <= tmrVal[g] + TMR_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/coinc_fire_ctrl.sv
module coinc_fire_ctrl
  import coinc_neuron_pkg::*;
#(
  parameter int SUM_W       = 9,
  parameter int REFRACT_CYC = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             coinc,
  input  logic [SUM_W-1:0] delaySum,
  output nrnStrobe_t       strb,
  output logic             postActive
);

  localparam int REF_W = $clog2(REFRACT_CYC + 1);
  localparam int CNT_W = (SUM_W > REF_W) ? SUM_W : REF_W;

  nrnState_t        state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strb.accept   = (state == ST_IDLE);
    strb.clearAll = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      postActive <= 1'b0;
    end else begin
      postActive <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (coinc) begin
            state <= ST_PEND;
            cnt   <= CNT_W'(delaySum);
          end
        end
        ST_PEND: begin
          if (cnt == '0) begin
            postActive <= 1'b1;
            if (REFRACT_CYC == 0) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_REFR;
              cnt   <= CNT_W'(REFRACT_CYC);
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_REFR: begin
          if (cnt <= CNT_W'(1)) state <= ST_IDLE;
          cnt <= cnt - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/coinc_neuron.sv
module coinc_neuron
  import coinc_neuron_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_SYN    = 4,
  parameter int THRESH     = 3,
  parameter int CLK_KHZ    = 66000,
  parameter int WINDOW_US  = 1000,
  parameter int REFRACT_US = 1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  selfAddr,
  input  logic [ADDR_W-1:0]  preAddr,
  input  logic [NUM_SYN-1:0] preActive,
  output logic [ADDR_W-1:0]  postAddr,
  output logic               postActive
);

  localparam int WINDOW_CYC  = CLK_KHZ * WINDOW_US / 1000;
  localparam int REFRACT_CYC = CLK_KHZ * REFRACT_US / 1000;
  localparam int TMR_W       = $clog2(WINDOW_CYC + 1);
  localparam int SUM_W       = TMR_W + $clog2(NUM_SYN + 1);

  nrnStrobe_t         strb;
  logic               coinc;
  logic [SUM_W-1:0]   delaySum;
  logic [NUM_SYN-1:0] tmrLive;

  coinc_synapse_dp #(
    .ADDR_W(ADDR_W), .NUM_SYN(NUM_SYN), .THRESH(THRESH),
    .WINDOW_CYC(WINDOW_CYC), .TMR_W(TMR_W), .SUM_W(SUM_W)
  ) dp (
    .clk(clk), .rstN(rstN), .selfAddr(selfAddr), .preAddr(preAddr),
    .preActive(preActive), .strb(strb), .coinc(coinc),
    .delaySum(delaySum), .tmrLive(tmrLive)
  );

  coinc_fire_ctrl #(
    .SUM_W(SUM_W), .REFRACT_CYC(REFRACT_CYC)
  ) ctrl (
    .clk(clk), .rstN(rstN), .coinc(coinc), .delaySum(delaySum),
    .strb(strb), .postActive(postActive)
  );

  assign postAddr = selfAddr;

endmodule

// File: rtl/coinc_neuron_checker.sv
module coinc_neuron_checker #(
  parameter int ADDR_W      = 12,
  parameter int NUM_SYN     = 4,
  parameter int REFRACT_CYC = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  selfAddr,
  input logic [ADDR_W-1:0]  postAddr,
  input logic               postActive,
  input logic               coinc,
  input logic [NUM_SYN-1:0] tmrLive
);

  localparam int GAP_W = $clog2(REFRACT_CYC + 2);

  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gap <= '0;
    else if (postActive) gap <= GAP_W'(REFRACT_CYC + 1);
    else if (gap != '0) gap <= gap - GAP_W'(1);
  end

  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    postActive |=> !postActive);

  a_r7_own_address: assert property (@(posedge clk) disable iff (!rstN)
    postActive |-> (postAddr == selfAddr));

  a_r8_refractory_gap: assert property (@(posedge clk) disable iff (!rstN)
    postActive |-> (gap == '0));

  a_r10_timers_cleared: assert property (@(posedge clk) disable iff (!rstN)
    coinc |=> (tmrLive == '0));

  a_r5_live_below_threshold: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tmrLive) <= 2);

endmodule

bind coinc_neuron coinc_neuron_checker #(
  .ADDR_W(ADDR_W), .NUM_SYN(NUM_SYN), .REFRACT_CYC(REFRACT_CYC)
) chk (
  .clk(clk), .rstN(rstN), .selfAddr(selfAddr), .postAddr(postAddr),
  .postActive(postActive), .coinc(coinc), .tmrLive(tmrLive)
);

// File: tb/coinc_neuron_test.sv
module coinc_neuron_test;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 64;
  localparam int R    = 16;
  localparam logic [11:0] SELF  = 12'h2A5;
  localparam logic [11:0] OTHER = 12'h2A4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] preAddr = '0;
  logic [3:0]  preActive = '0;
  logic [11:0] postAddr;
  logic        postActive;

  int errors = 0, checks = 0, cyc = 0;
  int fireCnt = 0, lastFire = -1, addrErr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  coinc_neuron #(
    .ADDR_W(12), .NUM_SYN(4), .THRESH(3),
    .CLK_KHZ(64), .WINDOW_US(1000), .REFRACT_US(250)
  ) uut (
    .clk(clk), .rstN(rstN), .selfAddr(SELF), .preAddr(preAddr),
    .preActive(preActive), .postAddr(postAddr), .postActive(postActive)
  );

  always @(negedge clk) begin
    if (rstN && postActive) begin
      fireCnt  = fireCnt + 1;
      lastFire = cyc;
      if (postAddr != SELF) addrErr = addrErr + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive one event; returns the rising-edge index that samples it
  task automatic send(input logic [3:0] lines, input logic [11:0] addr, output int edgeIdx);
    preAddr   = addr;
    preActive = lines;
    @(negedge clk);
    edgeIdx   = cyc;
    preActive = '0;
  endtask

  task automatic t_reset;
    chk(postActive == 1'b0, "R1 reset strobe", int'(postActive), 0);
    chk(postAddr == SELF, "R7 address at rest", int'(postAddr), int'(SELF));
    idle(30);
    chk(fireCnt == 0, "R1 quiet without input", fireCnt, 0);
  endtask

  task automatic t_simultaneous;
    int e, f0;
    idle(100); f0 = fireCnt;
    send(4'b0111, SELF, e);
    idle(5);
    chk(fireCnt - f0 == 1, "R5 three same-edge hits fire", fireCnt - f0, 1);
    chk(lastFire == e + 1, "R6 zero-sum delay", lastFire, e + 1);
  endtask

  task automatic t_two_only;
    int e, f0;
    idle(100); f0 = fireCnt;
    send(4'b0011, SELF, e);
    idle(100);
    chk(fireCnt == f0, "R5 two synapses do not fire", fireCnt - f0, 0);
  endtask

  task automatic t_spread;
    int e0, e1, e2, f0, exp;
    idle(100); f0 = fireCnt; addrErr = 0;
    send(4'b0001, SELF, e0); idle(4);
    send(4'b0010, SELF, e1); idle(6);
    send(4'b0100, SELF, e2);
    exp = e2 + (e2 - e0) + (e2 - e1) + 1;
    idle(50);
    chk(fireCnt - f0 == 1, "R7 one single-cycle strobe", fireCnt - f0, 1);
    chk(lastFire == exp, "R6 spread delay", lastFire, exp);
    chk(addrErr == 0, "R7 postAddr during strobe", addrErr, 0);
  endtask

  task automatic t_address;
    int e, f0;
    idle(100); f0 = fireCnt;
    send(4'b0111, OTHER, e);
    idle(40);
    chk(fireCnt == f0, "R2 foreign address ignored", fireCnt - f0, 0);
    send(4'b0001, SELF, e); idle(2);
    send(4'b0110, OTHER, e);
    idle(150);
    chk(fireCnt == f0, "R2 mixed addresses ignored", fireCnt - f0, 0);
  endtask

  task automatic t_rehit;
    int e0, e1, e2, eX, f0, exp;
    idle(100); f0 = fireCnt;
    send(4'b0001, SELF, e0); idle(2);
    send(4'b0001, SELF, eX); idle(1);
    send(4'b0010, SELF, e1); idle(10);
    chk(fireCnt == f0, "R4 repeat hit not counted", fireCnt - f0, 0);
    send(4'b0100, SELF, e2);
    exp = e2 + (e2 - e0) + (e2 - e1) + 1;
    idle(80);
    chk(fireCnt - f0 == 1, "R4 fire after third synapse", fireCnt - f0, 1);
    chk(lastFire == exp, "R4 timer not restarted", lastFire, exp);
  endtask

  task automatic t_window;
    int e0, e1, e2, f0, exp;
    idle(100); f0 = fireCnt;
    send(4'b0001, SELF, e0);
    send(4'b0010, SELF, e1);
    idle(W - 2);
    send(4'b0100, SELF, e2);
    idle(100);
    chk(e2 - e0 == W, "R3 stimulus spacing", e2 - e0, W);
    chk(fireCnt == f0, "R3 expired at W", fireCnt - f0, 0);
    idle(100); f0 = fireCnt;
    send(4'b0001, SELF, e0);
    send(4'b0010, SELF, e1);
    idle(W - 3);
    send(4'b0100, SELF, e2);
    exp = e2 + (e2 - e0) + (e2 - e1) + 1;
    idle(2 * W + 10);
    chk(fireCnt - f0 == 1, "R3 live at W-1", fireCnt - f0, 1);
    chk(lastFire == exp, "R3 R6 delay at window edge", lastFire, exp);
  endtask

  task automatic t_refractory;
    int e, ef, eI, eL, e3, f0, exp;
    idle(100); f0 = fireCnt;
    send(4'b0111, SELF, e);
    ef = e + 1;
    idle(R);
    send(4'b0111, SELF, eI);
    send(4'b1000, SELF, eL);
    chk(eI == ef + R && eL == ef + R + 1, "R8 probe edges", eI - ef, R);
    idle(10);
    chk(fireCnt - f0 == 1, "R8 hits at edge R ignored", fireCnt - f0, 1);
    send(4'b0011, SELF, e3);
    exp = e3 + (e3 - eL) + 1;
    idle(40);
    chk(fireCnt - f0 == 2, "R8 hit at edge R+1 accepted", fireCnt - f0, 2);
    chk(lastFire == exp, "R8 delay after refractory", lastFire, exp);
  endtask

  task automatic t_clear;
    int e, e2, f0;
    idle(100); f0 = fireCnt;
    send(4'b0111, SELF, e);
    idle(R + 2);
    send(4'b1001, SELF, e2);
    idle(40);
    chk(fireCnt - f0 == 1, "R10 earlier hits cleared", fireCnt - f0, 1);
  endtask

  task automatic t_pending;
    int e0, e1, e2, eX, f0, exp;
    idle(100); f0 = fireCnt;
    send(4'b0001, SELF, e0); idle(9);
    send(4'b0010, SELF, e1); idle(9);
    send(4'b0100, SELF, e2);
    exp = e2 + (e2 - e0) + (e2 - e1) + 1;
    idle(5);
    send(4'b1011, SELF, eX);
    idle(100);
    chk(fireCnt - f0 == 1, "R9 one spike per burst", fireCnt - f0, 1);
    chk(lastFire == exp, "R9 pending delay unchanged", lastFire, exp);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_simultaneous;
    t_two_only;
    t_spread;
    t_address;
    t_rehit;
    t_window;
    t_refractory;
    t_clear;
    t_pending;
    done = 1;
    summary;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      summary;
      $finish;
    end
  end

endmodule